// File: doc/BRIEF.md
# Four-Modulus Programmable Clock Divider

The block divides a fast clock by 20, 23, 24 or 25. A two-bit select picks the ratio. Inside, a three-flop dual-modulus prescaler divides the fast clock by 4 or by 5, depending on a modulus line. A five-step frame counter counts prescaler periods. A sequencer drives the modulus line during each frame, so that some prescaler periods are 4 fast cycles long and the rest are 5. The sum of the five periods in a frame is the total ratio.

Everything runs in the fast clock domain. The prescaler reports the start of each of its own periods as a one-cycle enable. The counter and the sequencer advance on that enable, so no derived clocks are created. The select is captured once per frame, at the wrap of the frame counter. A new select therefore takes effect on the next frame boundary and never splits a frame. The final output is high for the first prescaler period of each frame.

Top module: `fourmod_divider`

## Requirements
- R1: With `ratio_sel` = 2'b00, consecutive rising edges of `div_out` are 20 fast-clock cycles apart, and all five prescaler periods of the frame last 4 cycles.
- R2: With `ratio_sel` = 2'b01, consecutive rising edges of `div_out` are 23 fast-clock cycles apart.
- R3: With `ratio_sel` = 2'b10, consecutive rising edges of `div_out` are 24 fast-clock cycles apart.
- R4: With `ratio_sel` = 2'b11, consecutive rising edges of `div_out` are 25 fast-clock cycles apart, and all five prescaler periods last 5 cycles.
- R5: The prescaler period, measured between rising edges of `pre_out`, is 4 cycles while the modulus line is high and 5 cycles while it is low. The divide-by-4 periods come first in the frame: for 2'b01 the sequence starting at a `div_out` rise is 4,4,5,5,5, and for 2'b10 it is 4,5,5,5,5.
- R6: `ratio_sel` is sampled only at the frame boundary, which is the fast-clock edge on which `div_out` rises. If the select changes in mid-frame, the frame in progress keeps the old ratio and the next frame uses the new one.
- R7: `div_out` is high for exactly the first prescaler period of each frame. The high time is 4 cycles when that period divides by 4 and 5 cycles when it divides by 5.
- R8: While `rst_n` is low at a clock edge, `pre_out` and `div_out` are low. After release, `div_out` first rises on the second fast-clock edge, and that first frame already has the selected length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 2 | Ratio select: 00→20, 01→23, 10→24, 11→25 |
| pre_out | output | 1 | Prescaler output, one pulse per 4 or 5 fast cycles |
| div_out | output | 1 | Divided output, high for the first prescaler period of each frame |

## Verification
The bench builds the block with its default frame length of five prescaler periods and the two-bit select. This covers every ratio code and both prescaler moduli, so each mixture of 4-cycle and 5-cycle periods can be measured edge by edge against its expected position in the frame. Changing the select in mid-frame and measuring the first full frame after reset check the boundary sampling and the reset alignment.

// File: rtl/fmd_pkg.sv
// Shared types and helpers for the four-modulus divider.
package fmd_pkg;

    // Ratio select encodings
    typedef enum logic [1:0] {
        SEL_R20 = 2'b00,
        SEL_R23 = 2'b01,
        SEL_R24 = 2'b10,
        SEL_R25 = 2'b11
    } ratio_sel_e;

    // Number of divide-by-4 prescaler periods per frame for a select code
    function automatic int unsigned quad_periods(ratio_sel_e sel);
        case (sel)
            SEL_R20: return 5;
            SEL_R23: return 2;
            SEL_R24: return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dm_prescaler.sv
// Three-flop 4/5 dual-modulus prescaler.
// Divides by 4 while mod4 is high and by 5 while it is low. The decision
// is taken on the edge that leaves state 110. Assumes mod4 changes only
// on the edge that enters that state (the edge flagged by period_start).
module dm_prescaler (
    input  logic clk,
    input  logic rst_n,
    input  logic mod4,
    output logic pre_clk,
    output logic period_start
);
    logic s_a, s_b, s_c;

    // State loop: a takes NOR(b,c), b follows a, c is b gated by the modulus line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_a <= 1'b0;
            s_b <= 1'b0;
            s_c <= 1'b0;
        end else begin
            s_a <= ~(s_b | s_c);
            s_b <= s_a;
            s_c <= s_b & ~mod4;
        end
    end

    assign pre_clk      = s_b;
    // Next edge raises pre_clk and opens a new prescaler period
    assign period_start = s_a & ~s_b;

    // R5: the loop never enters the two unused states 101 and 111
    a_r5_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_a && s_c));

    // R5: the modulus line moves only together with a pre_clk rise
    a_r5_mod_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mod4) |-> (s_b && !$past(s_b)));

endmodule

// File: rtl/frame_counter.sv
// Modulo-FRAME_LEN counter of prescaler periods.
// Advances when step is high. Resets to the last index, so the first
// step after reset wraps and opens frame zero.
module frame_counter #(
    parameter int unsigned FRAME_LEN = 5,
    localparam int unsigned IDX_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx_nxt,
    output logic             wrap
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    logic [IDX_W-1:0] idx;

    // Wrap flag and next index for this step
    always_comb begin
        wrap    = step && (idx == LAST);
        idx_nxt = (idx == LAST) ? '0 : idx + 1'b1;
    end

    // Index register, moved one place per prescaler period
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= LAST;
        else if (step) idx <= idx_nxt;
    end

    // R7: the index stays inside the frame
    a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(FRAME_LEN));

    // R6: the index moves only on a prescaler period start
    a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(idx));

endmodule

// File: rtl/mod_sequencer.sv
// Captures the ratio select at each frame wrap and drives the modulus
// line for each prescaler period. The first quad_periods() periods of a
// frame divide by 4. Also drives the frame output pulse.
module mod_sequencer
    import fmd_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 5,
    localparam int unsigned IDX_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wrap,
    input  logic [IDX_W-1:0] idx_nxt,
    input  logic [1:0]       sel,
    output logic             mod4,
    output logic             frame_pulse
);
    ratio_sel_e  sel_q;
    ratio_sel_e  sel_use;
    int unsigned quad_n;

    // Select that rules the period being opened
    always_comb begin
        sel_use = wrap ? ratio_sel_e'(sel) : sel_q;
        quad_n  = quad_periods(sel_use);
    end

    // Select capture, only on the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= SEL_R25;
        else if (wrap) sel_q <= ratio_sel_e'(sel);
    end

    // Modulus line and frame pulse, refreshed at each period start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod4        <= 1'b0;
            frame_pulse <= 1'b0;
        end else if (step) begin
            mod4        <= (int'(idx_nxt) < quad_n);
            frame_pulse <= (idx_nxt == '0);
        end
    end

    // R6: the captured select stays frozen away from the wrap
    a_r6_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(sel_q));

    // R7: the frame pulse ends at the next period start
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (step && frame_pulse) |=> !frame_pulse);

    // R4: a 25 frame never requests divide-by-4
    a_r4_no_quad: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sel_use == SEL_R25) |=> !mod4);

endmodule

// File: rtl/fourmod_divider.sv
// Four-modulus divider top: divides clk_fast by 20, 23, 24 or 25.
// Assumes ratio_sel is synchronous to clk_fast. The select is sampled
// on the edge on which div_out rises.
module fourmod_divider #(
    parameter int unsigned FRAME_LEN = 5,
    localparam int unsigned IDX_W = $clog2(FRAME_LEN)
) (
    input  logic       clk_fast,
    input  logic       rst_n,
    input  logic [1:0] ratio_sel,
    output logic       pre_out,
    output logic       div_out
);
    logic             mod4;
    logic             period_start;
    logic             wrap;
    logic [IDX_W-1:0] idx_nxt;

    dm_prescaler u_presc (
        .clk          (clk_fast),
        .rst_n        (rst_n),
        .mod4         (mod4),
        .pre_clk      (pre_out),
        .period_start (period_start)
    );

    frame_counter #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .step    (period_start),
        .idx_nxt (idx_nxt),
        .wrap    (wrap)
    );

    mod_sequencer #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .clk         (clk_fast),
        .rst_n       (rst_n),
        .step        (period_start),
        .wrap        (wrap),
        .idx_nxt     (idx_nxt),
        .sel         (ratio_sel),
        .mod4        (mod4),
        .frame_pulse (div_out)
    );

    // R8: outputs are low in the cycle after a reset edge
    a_r8_reset_low: assert property (@(posedge clk_fast)
        !rst_n |=> (!pre_out && !div_out));

endmodule

// File: tb/fourmod_divider_bench.sv
module fourmod_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       pre_out, div_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int div_rises = 0, div_last = 0, div_fall_last = 0, div_falls = 0;
    int pre_rises = 0, pre_last = 0;
    logic div_prev = 1'b0, pre_prev = 1'b0;

    fourmod_divider u_fourmod_divider (
        .clk_fast  (clk_fast_w),
        .rst_n     (rst_n),
        .ratio_sel (sel),
        .pre_out   (pre_out),
        .div_out   (div_out)
    );
    wire clk_fast_w = clk;

    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    // Edge stamps taken away from the active edge
    always @(negedge clk) begin
        if (div_out && !div_prev) begin div_last = cyc; div_rises++; end
        if (!div_out && div_prev) begin div_fall_last = cyc; div_falls++; end
        if (pre_out && !pre_prev) begin pre_last = cyc; pre_rises++; end
        div_prev = div_out;
        pre_prev = pre_out;
    end

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: all requirements, cycles %0d expected below %0d", cyc, 100000);
        summary();
        $finish;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_div_rise(output int stamp);
        int n0 = div_rises;
        wait (div_rises != n0);
        stamp = div_last;
    endtask

    task automatic wait_pre_rise(output int stamp);
        int n0 = pre_rises;
        wait (pre_rises != n0);
        stamp = pre_last;
    endtask

    // R8: reset state and first frame
    task automatic t_reset;
        int rel, r0, r1;
        @(negedge clk);
        chk("R8 pre_out in reset", int'(pre_out), 0);
        chk("R8 div_out in reset", int'(div_out), 0);
        sel = 2'b01;
        rst_n = 1'b1;
        rel = cyc;
        wait_div_rise(r0);
        chk("R8 first rise delay", r0 - rel, 2);
        wait_div_rise(r1);
        chk("R8 first frame length", r1 - r0, 23);
    endtask

    // R1..R4: steady period for one code over three frames
    task automatic t_ratio(logic [1:0] code, int exp, string req);
        int r0, r1;
        @(negedge clk);
        sel = code;
        wait_div_rise(r0);
        for (int i = 0; i < 3; i++) begin
            wait_div_rise(r1);
            chk(req, r1 - r0, exp);
            r0 = r1;
        end
    endtask

    // R5/R7: prescaler period sequence and pulse width within a frame
    task automatic t_pattern(logic [1:0] code, int q, string req);
        int r0, p0, p1, f;
        @(negedge clk);
        sel = code;
        wait_div_rise(r0);
        wait_div_rise(r0);
        p0 = pre_last;
        chk({req, " pre and div aligned"}, p0, r0);
        for (int k = 0; k < 5; k++) begin
            wait_pre_rise(p1);
            chk(req, p1 - p0, (k < q) ? 4 : 5);
            if (k == 0) begin
                f = div_fall_last;
                chk("R7 div_out high time", f - r0, (q > 0) ? 4 : 5);
            end
            p0 = p1;
        end
    endtask

    // R6: mid-frame select change waits for the boundary
    task automatic t_midframe;
        int r0, r1, r2;
        @(negedge clk);
        sel = 2'b00;
        wait_div_rise(r0);
        wait_div_rise(r0);
        repeat (7) @(negedge clk);
        sel = 2'b11;
        wait_div_rise(r1);
        chk("R6 frame keeps old ratio", r1 - r0, 20);
        wait_div_rise(r2);
        chk("R6 next frame new ratio", r2 - r1, 25);
        repeat (3) @(negedge clk);
        sel = 2'b10;
        wait_div_rise(r1);
        chk("R6 second change old ratio", r1 - r2, 25);
        wait_div_rise(r2);
        chk("R6 second change new ratio", r2 - r1, 24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ratio(2'b00, 20, "R1 ratio 20");
        t_ratio(2'b01, 23, "R2 ratio 23");
        t_ratio(2'b10, 24, "R3 ratio 24");
        t_ratio(2'b11, 25, "R4 ratio 25");
        t_pattern(2'b01, 2, "R5 pattern 01");
        t_pattern(2'b10, 1, "R5 pattern 10");
        t_pattern(2'b00, 5, "R1 pattern 00");
        t_pattern(2'b11, 0, "R4 pattern 11");
        t_midframe();
        summary();
        $finish;
    end
endmodule